// File: doc/BRIEF.md
# Load/Store Port Requester

This block sits on the compute-unit side of a memory port that handles one request at a time. A command channel hands it an operation (load or store), an address, a byte length and, for stores, the data to write. The block presents the request to the memory side, keeps the address and its valid flag steady for as long as the memory side needs them, and follows the memory side's busy, address-accepted, address-exception and load-valid signals. When the request is over, it returns exactly one response strobe to the command side. The strobe carries the loaded data or an error flag.

The controller has five states:
- `S_IDLE` waits for a command.
- `S_ADDR` presents the address and waits for the memory side to accept or refuse it.
- `S_ST_PULSE` is the single cycle in which store data is marked valid.
- `S_ST_HOLD` keeps the request lines up after the store pulse until busy is seen low.
- `S_LD_WAIT` waits, with no time limit, for the load-valid pulse.

The transitions are:
- `S_IDLE`→`S_ADDR` when a command with a legal length is accepted.
- `S_ADDR`→`S_IDLE` on an address exception.
- `S_ADDR`→`S_ST_PULSE` or `S_ADDR`→`S_LD_WAIT` on address-accepted, depending on the operation.
- `S_ST_PULSE`→`S_ST_HOLD` always.
- `S_ST_HOLD`→`S_IDLE` once busy is low.
- `S_LD_WAIT`→`S_IDLE` on load-valid.
- Any state goes to `S_IDLE` when abort is high.

A command with an illegal length is answered at once with an error and never reaches the port.

Top module: `lsreq_fsm`

## Requirements
- R1: `cmd_ready_o` is high only when the controller is idle, `port_busy_i` is low and `abort_i` is low. A command held on `cmd_valid_i` is accepted on the first clock edge where `cmd_ready_o` is high, and never while busy is high.
- R2: From the cycle after a legal command is accepted until the request ends, exactly one request line is high. `port_st_o` is high when `cmd_store_i` was 1, and `port_ld_o` is high when it was 0. Both lines are low while idle.
- R3: `port_addr_o`, `port_len_o` and `port_addr_vld_o` appear in the same cycle and keep the command's values, unchanged, until the request ends. While idle all three are zero.
- R4: An address exception seen in `S_ADDR` ends the request. The next cycle shows `rsp_valid_o`=1 and `rsp_error_o`=1, with all port lines low and no store-data pulse.
- R5: For a store, `port_wdata_vld_o` is high for exactly one cycle: the cycle after address-accepted was seen. In that cycle `port_wdata_o` carries the command's store data. At all other times `port_wdata_o` is zero and the valid flag is low.
- R6: After the store pulse, the response (`rsp_valid_o`=1, `rsp_error_o`=0) comes in the next cycle. The request and address lines stay high until a cycle in which `port_busy_i` is low, and then drop.
- R7: For a load, the controller waits any number of cycles for `port_rdata_vld_i`. It captures `port_rdata_i` in that cycle and returns it on `rsp_rdata_o` with `rsp_error_o`=0 in the next cycle. The port lines drop in that same next cycle.
- R8: The legal lengths on `cmd_len_i` are 1, 2, 4 and 8 bytes. Any other value is accepted and answered in the next cycle with `rsp_valid_o`=1 and `rsp_error_o`=1, and no port line is raised.
- R9: After reset, or in the cycle after `abort_i` is high, the controller is idle and all port outputs are zero. An aborted request produces no response. Abort wins over any event in the same cycle, including a command, address-accepted and load-valid.
- R10: `rsp_valid_o` is a one-cycle strobe, issued once per finished request. `rsp_rdata_o` is zero except in a load's successful response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Synchronous abort back to idle |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be taken this cycle |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_len_i | input | 4 | Transfer length in bytes |
| cmd_wdata_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_error_o | output | 1 | Response is an error |
| rsp_rdata_o | output | DATA_W | Loaded data |
| port_ld_o | output | 1 | Load request line |
| port_st_o | output | 1 | Store request line |
| port_len_o | output | 4 | Length presented to the port |
| port_addr_o | output | ADDR_W | Address presented to the port |
| port_addr_vld_o | output | 1 | Address valid flag |
| port_wdata_o | output | DATA_W | Store data to the port |
| port_wdata_vld_o | output | 1 | One-cycle store data valid |
| port_busy_i | input | 1 | Memory side is busy |
| port_addr_ack_i | input | 1 | Address accepted pulse |
| port_addr_exc_i | input | 1 | Address exception pulse |
| port_rdata_i | input | DATA_W | Load data from the port |
| port_rdata_vld_i | input | 1 | Load data valid pulse |

## Verification
Two events can land on the same clock edge: an abort and a completion event. The completion event is address-accepted in `S_ADDR`, load-valid in `S_LD_WAIT`, or a command arriving while idle. The bench raises abort together with each of these. It judges that abort wins by checking that the next cycle shows idle port lines, no response strobe and no store pulse. A second overlap is an address exception that drops busy in the same cycle as a new command is driven. There the bench expects the error response and the acceptance of the new command on consecutive edges.

// File: rtl/lsreq_pkg.sv
package lsreq_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_ADDR     = 3'd1,
        S_ST_PULSE = 3'd2,
        S_ST_HOLD  = 3'd3,
        S_LD_WAIT  = 3'd4
    } lsreq_state_e;

    // transfer sizes the port understands: 1, 2, 4 or 8 bytes
    function automatic logic len_is_legal(input logic [LEN_W-1:0] len);
        logic ok;
        unique case (len)
            4'd1, 4'd2, 4'd4, 4'd8: ok = 1'b1;
            default:                ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/lsreq_cmd_hold.sv
module lsreq_cmd_hold
    import lsreq_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              store_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              store_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [DATA_W-1:0] wdata_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_o <= 1'b0;
            addr_o  <= '0;
            len_o   <= '0;
            wdata_o <= '0;
        end else if (load_i) begin
            store_o <= store_i;
            addr_o  <= addr_i;
            len_o   <= len_i;
            wdata_o <= wdata_i;
        end
    end

    // R3
    held_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> $stable(addr_o) && $stable(len_o));

endmodule

// File: rtl/lsreq_ctrl.sv
module lsreq_ctrl
    import lsreq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort_i,
    input  logic         cmd_valid_i,
    input  logic         len_ok_i,
    input  logic         is_store_i,
    input  logic         busy_i,
    input  logic         ack_i,
    input  logic         exc_i,
    input  logic         rdvld_i,
    output lsreq_state_e state_o,
    output logic         cmd_ready_o,
    output logic         take_o,
    output logic         ev_err_o,
    output logic         ev_ld_done_o,
    output logic         ev_st_done_o
);

    lsreq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid_i && !busy_i && len_ok_i) state_d = S_ADDR;
            end
            S_ADDR: begin
                if (exc_i)      state_d = S_IDLE;
                else if (ack_i) state_d = is_store_i ? S_ST_PULSE : S_LD_WAIT;
            end
            S_ST_PULSE: state_d = S_ST_HOLD;
            S_ST_HOLD: begin
                if (!busy_i) state_d = S_IDLE;
            end
            S_LD_WAIT: begin
                if (rdvld_i) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        if (abort_i) state_d = S_IDLE;
    end

    // outputs
    always_comb begin
        cmd_ready_o  = (state_q == S_IDLE) && !busy_i && !abort_i;
        take_o       = cmd_ready_o && cmd_valid_i;
        ev_err_o     = !abort_i && (((state_q == S_ADDR) && exc_i) ||
                                    (take_o && !len_ok_i));
        ev_ld_done_o = !abort_i && (state_q == S_LD_WAIT) && rdvld_i;
        ev_st_done_o = !abort_i && (state_q == S_ST_PULSE);
    end

    assign state_o = state_q;

    // R5
    pulse_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ST_PULSE) |-> $past(ack_i) && !$past(abort_i));

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ST_PULSE) |=> (state_q != S_ST_PULSE));

    // R1
    start_needs_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR) && $past(state_q == S_IDLE) |-> $past(cmd_valid_i && !busy_i));

    // R6
    hold_until_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == S_ST_HOLD) && $past(busy_i) && !$past(abort_i) |-> (state_q == S_ST_HOLD));

endmodule

// File: rtl/lsreq_rsp.sv
module lsreq_rsp #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_err_i,
    input  logic              ev_ld_done_i,
    input  logic              ev_st_done_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              valid_o,
    output logic              error_o,
    output logic [DATA_W-1:0] rdata_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            error_o <= 1'b0;
            rdata_o <= '0;
        end else begin
            valid_o <= ev_err_i || ev_ld_done_i || ev_st_done_i;
            error_o <= ev_err_i;
            rdata_o <= ev_ld_done_i ? rdata_i : '0;
        end
    end

    // R10
    rsp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> valid_o);

    // R10
    rsp_data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ev_ld_done_i) |-> (rdata_o == '0));

endmodule

// File: rtl/lsreq_fsm.sv
module lsreq_fsm
    import lsreq_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic              cmd_store_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [3:0]        cmd_len_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic              rsp_valid_o,
    output logic              rsp_error_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              port_ld_o,
    output logic              port_st_o,
    output logic [3:0]        port_len_o,
    output logic [ADDR_W-1:0] port_addr_o,
    output logic              port_addr_vld_o,
    output logic [DATA_W-1:0] port_wdata_o,
    output logic              port_wdata_vld_o,
    input  logic              port_busy_i,
    input  logic              port_addr_ack_i,
    input  logic              port_addr_exc_i,
    input  logic [DATA_W-1:0] port_rdata_i,
    input  logic              port_rdata_vld_i
);

    lsreq_state_e      st_q;
    logic              take, len_ok;
    logic              ev_err, ev_ld_done, ev_st_done;
    logic              h_store;
    logic [ADDR_W-1:0] h_addr;
    logic [LEN_W-1:0]  h_len;
    logic [DATA_W-1:0] h_wdata;
    logic              active;

    assign len_ok = len_is_legal(cmd_len_i);

    lsreq_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (take && len_ok),
        .store_i (cmd_store_i),
        .addr_i  (cmd_addr_i),
        .len_i   (cmd_len_i),
        .wdata_i (cmd_wdata_i),
        .store_o (h_store),
        .addr_o  (h_addr),
        .len_o   (h_len),
        .wdata_o (h_wdata)
    );

    lsreq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort_i      (abort_i),
        .cmd_valid_i  (cmd_valid_i),
        .len_ok_i     (len_ok),
        .is_store_i   (h_store),
        .busy_i       (port_busy_i),
        .ack_i        (port_addr_ack_i),
        .exc_i        (port_addr_exc_i),
        .rdvld_i      (port_rdata_vld_i),
        .state_o      (st_q),
        .cmd_ready_o  (cmd_ready_o),
        .take_o       (take),
        .ev_err_o     (ev_err),
        .ev_ld_done_o (ev_ld_done),
        .ev_st_done_o (ev_st_done)
    );

    lsreq_rsp #(.DATA_W(DATA_W)) u_rsp (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_err_i     (ev_err),
        .ev_ld_done_i (ev_ld_done),
        .ev_st_done_i (ev_st_done),
        .rdata_i      (port_rdata_i),
        .valid_o      (rsp_valid_o),
        .error_o      (rsp_error_o),
        .rdata_o      (rsp_rdata_o)
    );

    // port-side decode from the state and the held command
    always_comb begin
        active           = (st_q != S_IDLE);
        port_ld_o        = active && !h_store;
        port_st_o        = active && h_store;
        port_addr_vld_o  = active;
        port_addr_o      = active ? h_addr : '0;
        port_len_o       = active ? h_len  : '0;
        port_wdata_vld_o = (st_q == S_ST_PULSE);
        port_wdata_o     = port_wdata_vld_o ? h_wdata : '0;
    end

    // R3
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_addr_vld_o && $past(port_addr_vld_o) |-> $stable(port_addr_o) && $stable(port_len_o));

    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(abort_i) |-> !port_addr_vld_o && !port_ld_o && !port_st_o && !rsp_valid_o);

    // R4
    exc_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q == S_ADDR && port_addr_exc_i && !abort_i) |-> rsp_valid_o && rsp_error_o && !port_addr_vld_o && !port_wdata_vld_o);

    // R2
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_addr_vld_o |-> $countones({port_ld_o, port_st_o}) == 1);

    // R8
    bad_len_no_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && !len_is_legal(cmd_len_i)) |-> !port_addr_vld_o && rsp_error_o);

endmodule

// File: tb/test_lsreq_fsm.sv
module test_lsreq_fsm;

    localparam int AW = 48;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          abort_i = 1'b0;
    logic          cmd_valid_i = 1'b0;
    logic          cmd_store_i = 1'b0;
    logic [AW-1:0] cmd_addr_i = '0;
    logic [3:0]    cmd_len_i = '0;
    logic [DW-1:0] cmd_wdata_i = '0;
    logic          port_busy_i = 1'b0;
    logic          port_addr_ack_i = 1'b0;
    logic          port_addr_exc_i = 1'b0;
    logic [DW-1:0] port_rdata_i = '0;
    logic          port_rdata_vld_i = 1'b0;

    logic          cmd_ready_o, rsp_valid_o, rsp_error_o;
    logic [DW-1:0] rsp_rdata_o;
    logic          port_ld_o, port_st_o, port_addr_vld_o, port_wdata_vld_o;
    logic [3:0]    port_len_o;
    logic [AW-1:0] port_addr_o;
    logic [DW-1:0] port_wdata_o;

    always #5 clk = ~clk;

    lsreq_fsm #(.ADDR_W(AW), .DATA_W(DW)) i_lsreq_fsm (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
        .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
        .cmd_store_i(cmd_store_i), .cmd_addr_i(cmd_addr_i),
        .cmd_len_i(cmd_len_i), .cmd_wdata_i(cmd_wdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_error_o(rsp_error_o), .rsp_rdata_o(rsp_rdata_o),
        .port_ld_o(port_ld_o), .port_st_o(port_st_o), .port_len_o(port_len_o),
        .port_addr_o(port_addr_o), .port_addr_vld_o(port_addr_vld_o),
        .port_wdata_o(port_wdata_o), .port_wdata_vld_o(port_wdata_vld_o),
        .port_busy_i(port_busy_i), .port_addr_ack_i(port_addr_ack_i),
        .port_addr_exc_i(port_addr_exc_i), .port_rdata_i(port_rdata_i),
        .port_rdata_vld_i(port_rdata_vld_i)
    );

    // behavioural reference: phase 0 idle, 1 address, 2 store pulse, 3 store hold, 4 load wait
    int            ph = 0;
    bit            m_st = 0;
    logic [AW-1:0] m_addr = '0;
    logic [3:0]    m_len = '0;
    logic [DW-1:0] m_wd = '0;
    bit            m_rv = 0, m_re = 0;
    logic [DW-1:0] m_rd = '0;

    int    n_cmp = 0, n_bad = 0;
    string scen = "R9";
    bit    done = 0;

    function automatic bit legal(input logic [3:0] l);
        return (l == 1) || (l == 2) || (l == 4) || (l == 8);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_rv = 0; m_re = 0; m_rd = '0;
        end else begin
            m_rv = 0; m_re = 0; m_rd = '0;
            if (abort_i) ph = 0;
            else if (ph == 0) begin
                if (cmd_valid_i && !port_busy_i) begin
                    if (legal(cmd_len_i)) begin
                        ph = 1; m_st = cmd_store_i; m_addr = cmd_addr_i;
                        m_len = cmd_len_i; m_wd = cmd_wdata_i;
                    end else begin
                        m_rv = 1; m_re = 1;
                    end
                end
            end else if (ph == 1) begin
                if (port_addr_exc_i) begin m_rv = 1; m_re = 1; ph = 0; end
                else if (port_addr_ack_i) ph = m_st ? 2 : 4;
            end else if (ph == 2) begin
                m_rv = 1; ph = 3;
            end else if (ph == 3) begin
                if (!port_busy_i) ph = 0;
            end else if (ph == 4) begin
                if (port_rdata_vld_i) begin m_rv = 1; m_rd = port_rdata_i; ph = 0; end
            end
        end
    end

    task automatic cmp(input string tag, input string nm, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (scenario %s) %s actual=%h expected=%h at %0t", tag, scen, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit act;
        act = (ph != 0);
        cmp("R1",  "cmd_ready", 64'(cmd_ready_o), 64'((ph == 0) && !port_busy_i && !abort_i));
        cmp("R2",  "port_ld", 64'(port_ld_o), 64'(act && !m_st));
        cmp("R2",  "port_st", 64'(port_st_o), 64'(act && m_st));
        cmp("R3",  "addr_vld", 64'(port_addr_vld_o), 64'(act));
        cmp("R3",  "addr", 64'(port_addr_o), act ? 64'(m_addr) : 64'd0);
        cmp("R3",  "len", 64'(port_len_o), act ? 64'(m_len) : 64'd0);
        cmp("R5",  "wdata_vld", 64'(port_wdata_vld_o), 64'(ph == 2));
        cmp("R5",  "wdata", port_wdata_o, (ph == 2) ? m_wd : 64'd0);
        cmp("R10", "rsp_valid", 64'(rsp_valid_o), 64'(m_rv));
        cmp("R4",  "rsp_error", 64'(rsp_error_o), 64'(m_re));
        cmp("R7",  "rsp_rdata", rsp_rdata_o, m_rd);
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic give(input bit st, input logic [AW-1:0] a, input logic [3:0] l, input logic [DW-1:0] d);
        cmd_valid_i = 1; cmd_store_i = st; cmd_addr_i = a; cmd_len_i = l; cmd_wdata_i = d;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired (scenario %s)", scen);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        step(3);
        rst_n = 1; step(1);

        // R5 store with address wait
        scen = "R5";
        give(1, 48'h2, 4'd2, 64'hbeef); step(1);
        cmd_valid_i = 0; port_busy_i = 1; step(2);
        port_addr_ack_i = 1; step(1);
        port_addr_ack_i = 0; step(1);
        port_busy_i = 0; step(2);

        // R1 command held while busy, then R7 load with long wait
        scen = "R1";
        port_busy_i = 1; give(0, 48'h4, 4'd2, 64'h0); step(3);
        port_busy_i = 0; step(1);
        cmd_valid_i = 0; port_busy_i = 1; step(1);
        scen = "R7";
        port_addr_ack_i = 1; step(1);
        port_addr_ack_i = 0; step(5);
        port_rdata_vld_i = 1; port_rdata_i = 64'hf00f; port_busy_i = 0; step(1);
        port_rdata_vld_i = 0; port_rdata_i = '0; step(2);

        // R7 load with no wait after ack
        give(0, 48'h10, 4'd8, 64'h0); step(1);
        cmd_valid_i = 0; port_busy_i = 1; port_addr_ack_i = 1; step(1);
        port_addr_ack_i = 0; port_rdata_vld_i = 1; port_rdata_i = 64'h0123_4567_89ab_cdef; port_busy_i = 0; step(1);
        port_rdata_vld_i = 0; port_rdata_i = '0; step(2);

        // R4 exception, next command driven in same cycle busy falls
        scen = "R4";
        give(1, 48'h20, 4'd4, 64'h55); step(1);
        cmd_valid_i = 0; port_busy_i = 1; step(1);
        port_addr_exc_i = 1; port_busy_i = 0; give(0, 48'h30, 4'd1, 64'h0); step(1);
        port_addr_exc_i = 0; step(1);
        cmd_valid_i = 0; port_busy_i = 1; port_addr_ack_i = 1; step(1);
        port_addr_ack_i = 0; port_rdata_vld_i = 1; port_rdata_i = 64'hab; port_busy_i = 0; step(1);
        port_rdata_vld_i = 0; port_rdata_i = '0; step(2);

        // R8 illegal lengths
        scen = "R8";
        give(0, 48'h40, 4'd3, 64'h0); step(1);
        give(1, 48'h44, 4'd0, 64'h9); step(1);
        cmd_valid_i = 0; step(2);

        // R9 abort against load-valid, against ack, against a new command
        scen = "R9";
        give(0, 48'h50, 4'd2, 64'h0); step(1);
        cmd_valid_i = 0; port_busy_i = 1; port_addr_ack_i = 1; step(1);
        port_addr_ack_i = 0; step(2);
        abort_i = 1; port_rdata_vld_i = 1; port_rdata_i = 64'hdead; step(1);
        abort_i = 0; port_rdata_vld_i = 0; port_rdata_i = '0; port_busy_i = 0; step(2);
        give(1, 48'h60, 4'd8, 64'h77); step(1);
        cmd_valid_i = 0; abort_i = 1; port_addr_ack_i = 1; step(1);
        abort_i = 0; port_addr_ack_i = 0; step(2);
        give(1, 48'h70, 4'd1, 64'h1); abort_i = 1; step(1);
        abort_i = 0; cmd_valid_i = 0; step(2);

        // R6 store held while busy stays high, command waiting during hold
        scen = "R6";
        give(1, 48'h80, 4'd4, 64'hcafe_f00d); step(1);
        cmd_valid_i = 0; port_busy_i = 1; port_addr_ack_i = 1; step(1);
        port_addr_ack_i = 0; step(1);
        give(1, 48'h90, 4'd2, 64'h33); step(4);
        port_busy_i = 0; step(2);
        cmd_valid_i = 0; port_busy_i = 1; step(1);
        port_addr_exc_i = 1; port_busy_i = 0; step(1);
        port_addr_exc_i = 0; step(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule